// File: doc/BRIEF.md
# Exact-Rate Fractional Tick Synthesiser

This block derives an exact long-term 32768 Hz tick from a 10 MHz reference clock. There is no integer ratio between the two rates, so a power-of-two phase accumulator can only approximate the target. This block uses a phase accumulator whose modulus is 78125 (5^7). It adds 256 (2^8) on each enabled reference cycle. Since 10,000,000 × 256 / 78125 is exactly 32768, the average wrap rate carries no residual frequency error. Each wrap is reported as a one-cycle tick. A square wave is sliced from the phase. The current phase value is also exported.

A single 32768 Hz period is not a whole number of 100 ns reference periods. The tick spacing therefore alternates between 305 and 306 reference cycles. Only the average rate is exact, and the edge jitter is left to downstream analog cleanup.

A small sequencer records what the last reference edge did. Its states are:
- `ST_HALT`: entered on reset or when the enable is low.
- `ST_STEP`: the phase advanced without wrapping.
- `ST_WRAP`: the phase reached the modulus and wrapped.

Every edge makes one of three transitions:
- to `ST_HALT` when the enable is low,
- to `ST_WRAP` when the enabled sum reaches the modulus,
- to `ST_STEP` otherwise.

Any state can move to any other state. The tick output is high exactly while the sequencer is in `ST_WRAP`. The increment must be strictly less than the modulus; elaboration stops otherwise.

Top module: `frac_rate_synth`

## Requirements
- R1: A synchronous reset sets the phase to 0 and drives the tick and the square wave low on the cycle after the reset edge.
- R2: The phase output is 17 bits wide (default) and is always strictly below the modulus 78125.
- R3: Each enabled clock edge advances the phase by the increment 256, modulo 78125.
- R4: The tick is high for exactly the one cycle that follows an enabled edge whose sum reached or exceeded 78125, and it is low on every other cycle.
- R5: While the enable is low, the phase holds its value and the tick stays low.
- R6: The square wave is high exactly when the phase is at or above 39063, and low otherwise.
- R7: After 78125 enabled edges from reset, exactly 256 ticks have occurred and the phase is back at 0. This is equivalent to exactly 32768 ticks per 10,000,000 enabled cycles.
- R8: Under continuous enable, successive ticks are 305 or 306 cycles apart.
- R9: Over one full period of 78125 enabled edges from reset, the square wave is high on exactly 39062 of the sampled cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous reset, active high |
| run_i | input | 1 | Enable; when low, the phase is frozen |
| tick_o | output | 1 | One-cycle pulse on each phase wrap |
| wave_o | output | 1 | Square wave sliced from the phase |
| phase_o | output | 17 | Current accumulator phase |

## Verification
The embedded assertions check the following on every cycle:
- the phase stays below the modulus,
- the reset clears the phase and the tick,
- a disabled edge freezes the phase and silences the tick,
- the tick coincides with a drop in phase on each enabled step.

The long-range properties need the bench's scenarios. These are the exact tick count over one full period, the 305/306-cycle spacing, and the square wave's high count over a full period. The bench model also covers irregular enable patterns and a reset in mid-run.

// File: rtl/frac_rate_pkg.sv
package frac_rate_pkg;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_STEP = 2'd1,
        ST_WRAP = 2'd2
    } step_state_t;

endpackage

// File: rtl/frac_phase_acc.sv
module frac_phase_acc #(
    parameter int unsigned MODULUS   = 78125,
    parameter int unsigned INCREMENT = 256,
    localparam int unsigned PW       = $clog2(MODULUS)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          run_i,
    output logic [PW-1:0] phase_o,
    output logic          wrap_o
);
    localparam logic [PW:0] MOD_W = PW'(MODULUS);
    localparam logic [PW:0] INC_W = PW'(INCREMENT);

    logic [PW:0]   sum;
    logic [PW-1:0] phase_q;

    always_comb begin
        sum    = {1'b0, phase_q} + INC_W;
        wrap_o = (sum >= MOD_W);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phase_q <= '0;
        end else if (run_i) begin
            if (wrap_o) begin
                phase_q <= PW'(sum - MOD_W);
            end else begin
                phase_q <= sum[PW-1:0];
            end
        end
    end

    assign phase_o = phase_q;

    assert_phase_in_range_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        phase_q < MOD_W[PW-1:0]);

    assert_hold_when_idle_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        !run_i |=> $stable(phase_q));

    assert_reset_clears_R1: assert property (@(posedge clk_i)
        rst_i |=> (phase_q == '0));
endmodule

// File: rtl/frac_step_fsm.sv
module frac_step_fsm
    import frac_rate_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        run_i,
    input  logic        wrap_i,
    output step_state_t state_o,
    output logic        tick_o
);
    step_state_t state_q;
    step_state_t state_d;

    always_comb begin
        if (!run_i) begin
            state_d = ST_HALT;
        end else if (wrap_i) begin
            state_d = ST_WRAP;
        end else begin
            state_d = ST_STEP;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        tick_o = 1'b0;
        unique case (state_q)
            ST_HALT: tick_o = 1'b0;
            ST_STEP: tick_o = 1'b0;
            ST_WRAP: tick_o = 1'b1;
            default: tick_o = 1'b0;
        endcase
    end

    assign state_o = state_q;

    assert_no_tick_idle_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        !run_i |=> !tick_o);

    assert_tick_cleared_R1: assert property (@(posedge clk_i)
        rst_i |=> !tick_o);
endmodule

// File: rtl/frac_wave_slicer.sv
module frac_wave_slicer #(
    parameter int unsigned MODULUS = 78125,
    localparam int unsigned PW     = $clog2(MODULUS),
    localparam int unsigned HALF   = (MODULUS + 1) / 2
) (
    input  logic [PW-1:0] phase_i,
    output logic          wave_o
);
    always_comb begin
        wave_o = (phase_i >= PW'(HALF));
    end
endmodule

// File: rtl/frac_rate_synth.sv
module frac_rate_synth
    import frac_rate_pkg::*;
#(
    parameter int unsigned MODULUS   = 78125,
    parameter int unsigned INCREMENT = 256,
    localparam int unsigned PW       = $clog2(MODULUS)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          run_i,
    output logic          tick_o,
    output logic          wave_o,
    output logic [PW-1:0] phase_o
);
    if (INCREMENT >= MODULUS) begin : g_bad_params
        $error("increment must be below the modulus");
    end

    logic        wrap;
    step_state_t state;

    frac_phase_acc #(
        .MODULUS   (MODULUS),
        .INCREMENT (INCREMENT)
    ) u_acc (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .run_i   (run_i),
        .phase_o (phase_o),
        .wrap_o  (wrap)
    );

    frac_step_fsm u_fsm (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .run_i   (run_i),
        .wrap_i  (wrap),
        .state_o (state),
        .tick_o  (tick_o)
    );

    frac_wave_slicer #(
        .MODULUS (MODULUS)
    ) u_slice (
        .phase_i (phase_o),
        .wave_o  (wave_o)
    );

    // R4: a tick follows an enabled step exactly when the phase fell (wrapped)
    assert_tick_on_wrap_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        run_i |=> (tick_o == (phase_o < $past(phase_o))));

    assert_wave_low_reset_R1: assert property (@(posedge clk_i)
        rst_i |=> !wave_o);
endmodule

// File: tb/tb_frac_rate_synth.sv
module tb_frac_rate_synth;
    localparam int MODV = 78125;
    localparam int INCV = 256;
    localparam int HALFV = 39063;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic        tick;
    logic        wave;
    logic [16:0] phase;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    longint k = 0;     // enabled edges since reset
    bit exp_tick = 1'b0;

    always #5 clk = ~clk;

    frac_rate_synth dut (
        .clk_i   (clk),
        .rst_i   (rst),
        .run_i   (run),
        .tick_o  (tick),
        .wave_o  (wave),
        .phase_o (phase)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (k=%0d)", req, act, exp, k);
        end
    endtask

    // one clock: drive at negedge, update model at the edge, compare after it
    task automatic step(input bit r, input bit e);
        @(negedge clk);
        rst = r;
        run = e;
        @(posedge clk);
        #1;
        if (r) begin
            k = 0;
            exp_tick = 1'b0;
        end else if (e) begin
            k++;
            exp_tick = ((k * INCV) / MODV) != (((k - 1) * INCV) / MODV);
        end else begin
            exp_tick = 1'b0;
        end
        check("R3 phase", phase, (k * INCV) % MODV);
        check("R4 tick", tick, exp_tick);
        check("R6 wave", wave, (((k * INCV) % MODV) >= HALFV) ? 1 : 0);
        check("R2 range", (phase < MODV) ? 1 : 0, 1);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int ticks;
        int high;
        int last;
        int prev_phase;

        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        check("R1 reset phase", phase, 0);
        check("R1 reset tick", tick, 0);
        check("R1 reset wave", wave, 0);

        // full period under continuous enable
        ticks = 0; high = 0; last = -1;
        for (int i = 1; i <= MODV; i++) begin
            step(1'b0, 1'b1);
            if (wave) high++;
            if (tick) begin
                ticks++;
                if (last >= 0) check("R8 spacing ok", ((i - last) == 305 || (i - last) == 306) ? 1 : 0, 1);
                last = i;
            end
        end
        check("R7 tick count", ticks, 256);
        check("R7 phase back to zero", phase, 0);
        check("R9 wave high count", high, 39062);

        // frozen with enable low
        for (int i = 0; i < 40; i++) step(1'b0, 1'b1);
        prev_phase = phase;
        for (int i = 0; i < 50; i++) begin
            step(1'b0, 1'b0);
            check("R5 phase held", phase, prev_phase);
            check("R5 tick low", tick, 0);
        end

        // irregular enable patterns
        for (int i = 0; i < 3000; i++) step(1'b0, (i % 3) != 0);
        for (int i = 0; i < 2000; i++) step(1'b0, ((i * 7) % 11) > 4);

        // reset in mid-run
        step(1'b1, 1'b1);
        check("R1 mid reset phase", phase, 0);
        check("R1 mid reset tick", tick, 0);
        check("R1 mid reset wave", wave, 0);
        for (int i = 0; i < 700; i++) step(1'b0, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule